// File: doc/BRIEF.md
# Keyboard Key Ring Buffer

This block holds keystrokes inside a keyboard controller until the CPU gets round to collecting them. Key codes arrive from the scan side with a one-cycle valid strobe and are kept in a small circular store. The CPU side pulls the oldest waiting key with a read strobe. While the CPU or the system bus is busy, keys pile up. Once it is free again, back-to-back reads drain the whole burst in arrival order.

Two free-running position counters track the store. A write counter marks where the next key goes, and a read counter marks the next key to hand out. Occupancy is their difference, and each storage slot is a counter taken modulo the depth. When the two counters become equal, meaning the store is empty, both return to zero. Empty, full and the fill level come straight from the counter difference.

Top module: `kbd_ring_buffer`

## Requirements
- R1: After reset `fill_count` is 0, `is_empty` is 1, `is_full` is 0 and `key_out` is 0.
- R2: A key presented with `key_valid` high while `fill_count` is below DEPTH is stored, and `fill_count` rises by one at the next clock edge if there is no read in the same cycle.
- R3: A key presented while `fill_count` equals DEPTH is dropped. The stored keys are left unchanged, and later reads return only the keys that were already held.
- R4: A read strobe (`rd_req` high) while the store is not empty loads the oldest stored key onto `key_out` at the next clock edge and lowers `fill_count` by one. Keys come out in the order they were accepted.
- R5: A read strobe while the store is empty leaves `key_out` holding its previous value, and `fill_count` stays 0.
- R6: An accepted write and a valid read in the same cycle leave `fill_count` unchanged. The read returns the oldest key and the new key joins the tail.
- R7: `is_empty` is 1 exactly when `fill_count` is 0, and `is_full` is 1 exactly when `fill_count` equals DEPTH. Both follow the counters in the same cycle.
- R8: Whenever the write and read counters become equal, both are set to zero. First-in first-out order is kept across any number of drains and refills.
- R9: When the store is full and both strobes are high, the read is served and the write is dropped, so `fill_count` becomes DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_valid | input | 1 | One-cycle strobe: `key_code` holds a new key |
| key_code | input | KEY_W | Key code from the scan side |
| rd_req | input | 1 | CPU read strobe |
| key_out | output | KEY_W | Last key handed to the CPU (registered) |
| is_empty | output | 1 | No key waiting |
| is_full | output | 1 | DEPTH keys waiting |
| fill_count | output | $clog2(DEPTH)+1 | Number of keys waiting |

## Verification
A wrong counter or slot index shows up at the ports in one of two ways. Either `fill_count` or the flags differ from the expected value on the first edge after the faulty update, or a read returns the wrong key, which appears on `key_out` one edge after the strobe. A bad snap back to zero stays hidden until the next wrap of the slot index. For that reason the stimulus drains and refills the store many times with varying fill levels, so that every slot is reached from every offset. The drop-when-full and empty-read paths are also driven directly. Any loss or duplication there shows as a miscompare on the next key read.

// File: rtl/kbd_ring_pkg.sv
`timescale 1ns/1ps
package kbd_ring_pkg;

   // true when v is a power of two of at least 2
   function automatic bit depth_ok(input int v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   // per-cycle decision taken by the status logic
   typedef struct packed {
      logic take_key;
      logic give_key;
   } ring_op_t;

endpackage

// File: rtl/kbd_ring_ptrs.sv
`timescale 1ns/1ps
module kbd_ring_ptrs #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take_key,
   input  logic             give_key,
   output logic [CNT_W-1:0] wr_pos,
   output logic [CNT_W-1:0] rd_pos
);

   logic [CNT_W-1:0] wr_step;
   logic [CNT_W-1:0] rd_step;
   logic [CNT_W-1:0] wr_next;
   logic [CNT_W-1:0] rd_next;
   logic             meet;

   always_comb begin
      wr_step = {{(CNT_W-1){1'b0}}, take_key};
      rd_step = {{(CNT_W-1){1'b0}}, give_key};
      wr_next = wr_pos + wr_step;
      rd_next = rd_pos + rd_step;
      meet    = (wr_next == rd_next);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_pos <= '0;
         rd_pos <= '0;
      end else if (meet) begin
         wr_pos <= '0;
         rd_pos <= '0;
      end else begin
         wr_pos <= wr_next;
         rd_pos <= rd_next;
      end
   end

endmodule

// File: rtl/kbd_ring_status.sv
`timescale 1ns/1ps
module kbd_ring_status
   import kbd_ring_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int CNT_W = 4
) (
   input  logic             key_valid,
   input  logic             rd_req,
   input  logic [CNT_W-1:0] wr_pos,
   input  logic [CNT_W-1:0] rd_pos,
   output logic [CNT_W-1:0] level,
   output logic             none_held,
   output logic             all_held,
   output ring_op_t         op
);

   localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

   always_comb begin
      level        = wr_pos - rd_pos;
      none_held    = (level == '0);
      all_held     = (level == CAP);
      op.take_key  = key_valid && (level < CAP);
      op.give_key  = rd_req && !none_held;
   end

endmodule

// File: rtl/kbd_ring_store.sv
`timescale 1ns/1ps
module kbd_ring_store #(
   parameter int DEPTH = 8,
   parameter int KEY_W = 8,
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_slot,
   input  logic [KEY_W-1:0] wr_key,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_slot,
   output logic [KEY_W-1:0] rd_key
);

   logic [KEY_W-1:0] slot_q [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic hit;
      assign hit = wr_en && (wr_slot == IDX_W'(s));
      always_ff @(posedge clk) begin
         if (!rst_n)
            slot_q[s] <= '0;
         else if (hit)
            slot_q[s] <= wr_key;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rd_key <= '0;
      else if (rd_en)
         rd_key <= slot_q[rd_slot];
   end

endmodule

// File: rtl/kbd_ring_buffer.sv
`timescale 1ns/1ps
module kbd_ring_buffer
   import kbd_ring_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int KEY_W = 8,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = IDX_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_valid,
   input  logic [KEY_W-1:0] key_code,
   input  logic             rd_req,
   output logic [KEY_W-1:0] key_out,
   output logic             is_empty,
   output logic             is_full,
   output logic [CNT_W-1:0] fill_count
);

   if (!depth_ok(DEPTH)) begin : g_bad_depth
      $error("kbd_ring_buffer: DEPTH must be a power of two >= 2");
   end
   if (KEY_W < 1) begin : g_bad_width
      $error("kbd_ring_buffer: KEY_W must be at least 1");
   end

   logic [CNT_W-1:0] wr_pos;
   logic [CNT_W-1:0] rd_pos;
   ring_op_t         op;

   kbd_ring_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_status (
      .key_valid (key_valid),
      .rd_req    (rd_req),
      .wr_pos    (wr_pos),
      .rd_pos    (rd_pos),
      .level     (fill_count),
      .none_held (is_empty),
      .all_held  (is_full),
      .op        (op)
   );

   kbd_ring_ptrs #(.CNT_W(CNT_W)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_key (op.take_key),
      .give_key (op.give_key),
      .wr_pos   (wr_pos),
      .rd_pos   (rd_pos)
   );

   kbd_ring_store #(.DEPTH(DEPTH), .KEY_W(KEY_W), .IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (op.take_key),
      .wr_slot (wr_pos[IDX_W-1:0]),
      .wr_key  (key_code),
      .rd_en   (op.give_key),
      .rd_slot (rd_pos[IDX_W-1:0]),
      .rd_key  (key_out)
   );

endmodule

// File: rtl/kbd_ring_chk.sv
`timescale 1ns/1ps
module kbd_ring_chk #(
   parameter int DEPTH = 8,
   parameter int KEY_W = 8,
   parameter int CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             key_valid,
   input logic             rd_req,
   input logic [KEY_W-1:0] key_out,
   input logic             is_empty,
   input logic             is_full,
   input logic [CNT_W-1:0] fill_count,
   input logic [CNT_W-1:0] wr_pos,
   input logic [CNT_W-1:0] rd_pos
);

   localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (fill_count == '0) && (key_out == '0));

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && !is_full && !rd_req) |=> (fill_count == $past(fill_count) + ONE));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && is_full && !rd_req) |=> (fill_count == CAP));

   assert_read_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !is_empty && !key_valid) |=> (fill_count == $past(fill_count) - ONE));

   assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && is_empty) |=> $stable(key_out));

   assert_pair_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && key_valid && !is_empty && !is_full) |=> $stable(fill_count));

   assert_flag_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_empty == (fill_count == '0));

   assert_flag_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      is_full == (fill_count == CAP));

   assert_snap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pos == rd_pos) |-> (wr_pos == '0));

   assert_full_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && key_valid && is_full) |=> (fill_count == CAP - ONE));

endmodule

bind kbd_ring_buffer kbd_ring_chk #(.DEPTH(DEPTH), .KEY_W(KEY_W), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .key_valid  (key_valid),
   .rd_req     (rd_req),
   .key_out    (key_out),
   .is_empty   (is_empty),
   .is_full    (is_full),
   .fill_count (fill_count),
   .wr_pos     (wr_pos),
   .rd_pos     (rd_pos)
);

// File: tb/tb_kbd_ring_buffer.sv
`timescale 1ns/1ps
module tb_kbd_ring_buffer;

   localparam int DEPTH = 8;
   localparam int KEY_W = 8;
   localparam int CNT_W = $clog2(DEPTH) + 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             key_valid = 1'b0;
   logic [KEY_W-1:0] key_code = '0;
   logic             rd_req = 1'b0;
   logic [KEY_W-1:0] key_out;
   logic             is_empty;
   logic             is_full;
   logic [CNT_W-1:0] fill_count;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [KEY_W-1:0] mq [$];
   logic [KEY_W-1:0] exp_out = '0;

   always #2.5 clk = ~clk;

   kbd_ring_buffer #(.DEPTH(DEPTH), .KEY_W(KEY_W)) dut (
      .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key_code(key_code),
      .rd_req(rd_req), .key_out(key_out), .is_empty(is_empty),
      .is_full(is_full), .fill_count(fill_count)
   );

   function automatic bit model_accepts(input bit kv, input int level);
      return kv && (level < DEPTH);
   endfunction

   function automatic bit model_serves(input bit rr, input int level);
      return rr && (level > 0);
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // drive one cycle at the falling edge, update the model, compare after the rising edge
   task automatic step(input string tag, input bit kv, input logic [KEY_W-1:0] kc, input bit rr);
      int lvl;
      bit w;
      bit r;
      @(negedge clk);
      key_valid = kv;
      key_code  = kc;
      rd_req    = rr;
      lvl = mq.size();
      w = model_accepts(kv, lvl);
      r = model_serves(rr, lvl);
      if (r) exp_out = mq.pop_front();
      if (w) mq.push_back(kc);
      @(posedge clk);
      #1;
      check({tag, " level"}, int'(fill_count), mq.size());
      check({tag, " key"}, int'(key_out), int'(exp_out));
      check("R7 empty", int'(is_empty), int'(mq.size() == 0));
      check("R7 full", int'(is_full), int'(mq.size() == DEPTH));
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(5.0 * 200000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 level", int'(fill_count), 0);
      check("R1 empty", int'(is_empty), 1);
      check("R1 full", int'(is_full), 0);
      check("R1 key", int'(key_out), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5 read while empty after reset
      step("R5", 1'b0, 8'h00, 1'b1);

      // R2 fill to the top
      for (int i = 0; i < DEPTH; i++) step("R2", 1'b1, 8'h10 + 8'(i), 1'b0);
      // R3 extra keys dropped while full
      step("R3", 1'b1, 8'hEE, 1'b0);
      step("R3", 1'b1, 8'hEF, 1'b0);
      // R9 full, both strobes
      step("R9", 1'b1, 8'hDD, 1'b1);
      // R6 paired write and read in the middle
      step("R6", 1'b1, 8'h40, 1'b1);
      step("R6", 1'b1, 8'h41, 1'b1);
      // R4 drain in order, dropped keys must never appear
      for (int i = 0; i < DEPTH; i++) step("R4", 1'b0, 8'h00, 1'b1);
      // R5 empty read keeps last key, even with a write in the same cycle
      step("R5", 1'b0, 8'h00, 1'b1);
      step("R5", 1'b1, 8'h77, 1'b1);
      step("R4", 1'b0, 8'h00, 1'b1);
      step("R5", 1'b0, 8'h00, 1'b1);

      // R8 many drains and refills at varying depth, wrapping the slot index
      for (int round = 0; round < 60; round++) begin
         int n;
         n = 1 + ($urandom % DEPTH);
         for (int i = 0; i < n; i++) step("R8", 1'b1, 8'($urandom), 1'b0);
         while (mq.size() > 0) step("R8", 1'b0, 8'h00, 1'b1);
      end

      // mixed random traffic
      for (int i = 0; i < 3000; i++) begin
         bit kv;
         bit rr;
         kv = ($urandom % 100) < 55;
         rr = ($urandom % 100) < 50;
         step("R6 mix", kv, 8'($urandom), rr);
      end

      finish_run();
   end

endmodule